// File: doc/BRIEF.md
# Multi-Slave Transmit Gather Master

This block is the master end of a transmit byte-lane bus that several slaves share. It walks a programmable table of timeslots, one entry per clock, and raises a valid strobe to at most one slave per cycle. In slots that carry payload it also raises that slave's payload-request strobe. A selected slave answers on the following cycle. Every unselected slave holds its data bus at zero, so the block combines all slave buses with a bitwise OR into one bus and samples it.

A copy of each slot's slave index and payload bit is delayed by one cycle. The block uses it to route every captured byte to the stream output of the slave that produced it, together with its payload flag. Sparse schedules serve slow slaves at a low duty cycle, so the master alone sets the throughput. Idle slots make the combined bus a check point: any nonzero value seen there marks a slave that drove data without being selected.

The schedule table is loaded through a small write port. A run input starts and stops the slot sequence. A last-entry input sets how many table entries are active.

Top module: `tx_gather_master`

## Requirements
- R1: After reset, every valid strobe, payload strobe, stream valid and `coll_err` is low. The table holds only idle entries, and the first slot issued once `run` is high comes from entry 0.
- R2: While `run` is high, the entry at the schedule pointer is issued on each clock edge. The pointer steps 0, 1, … up to `sched_last` and then wraps to 0. At most one bit of `tx_val` is high, and it is the bit of the slave index held in that entry.
- R3: A bit of `tx_pay` is high only together with the same bit of `tx_val`, and only when the issued entry has its payload bit set to 1.
- R4: An entry whose slave field is `NUM_SLAVES` or greater (3 or 2'b11 with the defaults) is idle. No valid strobe is raised in its slot.
- R5: The combined bus is the bitwise OR of all slave buses. For a slot issued at edge k, the byte is sampled at edge k+2. It appears on `out_byte`, with the bit of that slave set in `out_vld` and `out_pay` equal to the entry's payload bit. Both are held at zero when no stream is valid.
- R6: Back-to-back slots, whether to the same slave or to different slaves, each deliver their own byte, in order, with no byte lost or duplicated.
- R7: `coll_err` pulses for one cycle, two edges after an idle slot, when the combined bus sampled in the cycle after that slot is nonzero. It stays low otherwise.
- R8: While `run` is low, no strobe is issued and the pointer is held at entry 0. Raising `run` restarts the schedule at entry 0.
- R9: A write with `cfg_we` high stores `cfg_slave` and `cfg_pay` into entry `cfg_addr` at the clock edge. A slot issued at that same edge still uses the old contents, and later slots use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables slot sequencing |
| sched_last | input | PTR_W | Index of the last active table entry |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | PTR_W | Table entry to write |
| cfg_slave | input | SIDX_W | Slave index for the entry (≥ NUM_SLAVES means idle) |
| cfg_pay | input | 1 | Payload bit for the entry |
| tx_val | output | NUM_SLAVES | Per-slave valid strobe |
| tx_pay | output | NUM_SLAVES | Per-slave payload-request strobe |
| slv_dat | input | NUM_SLAVES*LANE_W | Slave data buses, slave i in bits [i*LANE_W +: LANE_W] |
| out_vld | output | NUM_SLAVES | Per-slave stream valid |
| out_pay | output | 1 | Payload flag of the routed byte |
| out_byte | output | LANE_W | Routed byte |
| coll_err | output | 1 | Nonzero bus after an idle slot |

## Verification
The bench aims at the one-cycle skew between strobe and data. If the delayed slot copy were missing or too long, bytes would be credited to the slave in the neighbouring slot, and the scoreboard would see wrong values arrive at the wrong cycle. Idle slots, the wrap at `sched_last`, a single-entry schedule and a restart after `run` falls probe the pointer: an off-by-one there shifts the whole strobe pattern. A write made while the schedule runs would take effect one slot early if the table read were bypassed. A slave that drives data outside its slot is injected after an idle slot, so that a wrong collision check shows up either as a missed pulse or as a false one.

// File: rtl/tgm_pkg.sv
package tgm_pkg;
    localparam int TGM_NUM_SLAVES_DEF = 3;
    localparam int TGM_LANE_W_DEF     = 8;
    localparam int TGM_DEPTH_DEF      = 16;
endpackage

// File: rtl/tgm_sched_table.sv
module tgm_sched_table #(
    parameter int DEPTH  = 16,
    parameter int SIDX_W = 2,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [SIDX_W-1:0] wslave,
    input  logic              wpay,
    input  logic [PTR_W-1:0]  raddr,
    output logic [SIDX_W-1:0] rslave,
    output logic              rpay
);
    localparam int ENT_W = SIDX_W + 1;
    localparam logic [ENT_W-1:0] IDLE_ENT = {{SIDX_W{1'b1}}, 1'b0};

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] tbl;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we && (waddr == PTR_W'(i))) begin
                st_d.tbl[i] = {wslave, wpay};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tbl <= {DEPTH{IDLE_ENT}};
        end else begin
            st_q <= st_d;
        end
    end

    logic [ENT_W-1:0] rd_ent;
    always_comb begin
        rd_ent = IDLE_ENT;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == PTR_W'(i)) begin
                rd_ent = st_q.tbl[i];
            end
        end
    end

    assign rslave = rd_ent[ENT_W-1:1];
    assign rpay   = rd_ent[0];
endmodule

// File: rtl/tgm_slot_seq.sv
module tgm_slot_seq #(
    parameter int NUM_SLAVES = 3,
    parameter int SIDX_W     = 2,
    parameter int PTR_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [PTR_W-1:0]      last,
    input  logic [SIDX_W-1:0]     ent_slave,
    input  logic                  ent_pay,
    output logic [PTR_W-1:0]      ptr,
    output logic [NUM_SLAVES-1:0] val,
    output logic [NUM_SLAVES-1:0] pay,
    output logic [SIDX_W-1:0]     slot_sel,
    output logic                  slot_pay
);
    localparam logic [SIDX_W-1:0] IDLE_IDX = SIDX_W'(NUM_SLAVES);

    typedef struct packed {
        logic [PTR_W-1:0]      ptr;
        logic [NUM_SLAVES-1:0] val;
        logic [NUM_SLAVES-1:0] pay;
        logic [SIDX_W-1:0]     sel;
        logic                  spay;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       ent_busy;

    assign ent_busy = (ent_slave < IDLE_IDX);

    always_comb begin
        st_d      = st_q;
        st_d.val  = '0;
        st_d.pay  = '0;
        st_d.sel  = IDLE_IDX;
        st_d.spay = 1'b0;
        if (!run) begin
            st_d.ptr = '0;
        end else begin
            if (ent_busy) begin
                st_d.sel  = ent_slave;
                st_d.spay = ent_pay;
            end
            for (int i = 0; i < NUM_SLAVES; i++) begin
                if (ent_busy && (ent_slave == SIDX_W'(i))) begin
                    st_d.val[i] = 1'b1;
                    st_d.pay[i] = ent_pay;
                end
            end
            if (st_q.ptr >= last) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.val  <= '0;
            st_q.pay  <= '0;
            st_q.sel  <= IDLE_IDX;
            st_q.spay <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr      = st_q.ptr;
    assign val      = st_q.val;
    assign pay      = st_q.pay;
    assign slot_sel = st_q.sel;
    assign slot_pay = st_q.spay;
endmodule

// File: rtl/tgm_gather.sv
module tgm_gather #(
    parameter int NUM_SLAVES = 3,
    parameter int LANE_W     = 8,
    parameter int SIDX_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SIDX_W-1:0]            slot_sel,
    input  logic                         slot_pay,
    input  logic [NUM_SLAVES*LANE_W-1:0] slv_dat,
    output logic [NUM_SLAVES-1:0]        out_vld,
    output logic                         out_pay,
    output logic [LANE_W-1:0]            out_byte,
    output logic                         coll_err
);
    localparam logic [SIDX_W-1:0] IDLE_IDX = SIDX_W'(NUM_SLAVES);

    typedef struct packed {
        logic [SIDX_W-1:0]     dsel;
        logic                  dpay;
        logic [NUM_SLAVES-1:0] vld;
        logic                  pay;
        logic [LANE_W-1:0]     dat;
        logic                  err;
    } gat_state_t;

    gat_state_t        st_d, st_q;
    logic [LANE_W-1:0] or_bus;
    logic              dsel_idle;

    always_comb begin
        or_bus = '0;
        for (int i = 0; i < NUM_SLAVES; i++) begin
            or_bus = or_bus | slv_dat[i*LANE_W +: LANE_W];
        end
    end

    assign dsel_idle = (st_q.dsel >= IDLE_IDX);

    always_comb begin
        st_d      = st_q;
        st_d.dsel = slot_sel;
        st_d.dpay = slot_pay;
        st_d.vld  = '0;
        for (int i = 0; i < NUM_SLAVES; i++) begin
            if (st_q.dsel == SIDX_W'(i)) begin
                st_d.vld[i] = 1'b1;
            end
        end
        st_d.pay = dsel_idle ? 1'b0 : st_q.dpay;
        st_d.dat = dsel_idle ? '0 : or_bus;
        st_d.err = dsel_idle && (or_bus != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dsel <= IDLE_IDX;
            st_q.dpay <= 1'b0;
            st_q.vld  <= '0;
            st_q.pay  <= 1'b0;
            st_q.dat  <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_pay  = st_q.pay;
    assign out_byte = st_q.dat;
    assign coll_err = st_q.err;
endmodule

// File: rtl/tx_gather_master.sv
module tx_gather_master #(
    parameter int NUM_SLAVES = tgm_pkg::TGM_NUM_SLAVES_DEF,
    parameter int LANE_W     = tgm_pkg::TGM_LANE_W_DEF,
    parameter int DEPTH      = tgm_pkg::TGM_DEPTH_DEF,
    localparam int SIDX_W    = $clog2(NUM_SLAVES + 1),
    localparam int PTR_W     = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic [PTR_W-1:0]             sched_last,
    input  logic                         cfg_we,
    input  logic [PTR_W-1:0]             cfg_addr,
    input  logic [SIDX_W-1:0]            cfg_slave,
    input  logic                         cfg_pay,
    output logic [NUM_SLAVES-1:0]        tx_val,
    output logic [NUM_SLAVES-1:0]        tx_pay,
    input  logic [NUM_SLAVES*LANE_W-1:0] slv_dat,
    output logic [NUM_SLAVES-1:0]        out_vld,
    output logic                         out_pay,
    output logic [LANE_W-1:0]            out_byte,
    output logic                         coll_err
);
    logic [PTR_W-1:0]  rd_ptr;
    logic [SIDX_W-1:0] ent_slave;
    logic              ent_pay;
    logic [SIDX_W-1:0] slot_sel;
    logic              slot_pay;

    tgm_sched_table #(.DEPTH(DEPTH), .SIDX_W(SIDX_W), .PTR_W(PTR_W)) tbl_i (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .waddr(cfg_addr), .wslave(cfg_slave), .wpay(cfg_pay),
        .raddr(rd_ptr), .rslave(ent_slave), .rpay(ent_pay)
    );

    tgm_slot_seq #(.NUM_SLAVES(NUM_SLAVES), .SIDX_W(SIDX_W), .PTR_W(PTR_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .run(run), .last(sched_last),
        .ent_slave(ent_slave), .ent_pay(ent_pay), .ptr(rd_ptr),
        .val(tx_val), .pay(tx_pay), .slot_sel(slot_sel), .slot_pay(slot_pay)
    );

    tgm_gather #(.NUM_SLAVES(NUM_SLAVES), .LANE_W(LANE_W), .SIDX_W(SIDX_W)) gat_i (
        .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .slot_pay(slot_pay),
        .slv_dat(slv_dat), .out_vld(out_vld), .out_pay(out_pay),
        .out_byte(out_byte), .coll_err(coll_err)
    );
endmodule

// File: rtl/tx_gather_master_chk.sv
module tx_gather_master_chk #(
    parameter int NUM_SLAVES = 3,
    parameter int LANE_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic [NUM_SLAVES-1:0] tx_val,
    input logic [NUM_SLAVES-1:0] tx_pay,
    input logic [NUM_SLAVES-1:0] out_vld,
    input logic                  out_pay,
    input logic [LANE_W-1:0]     out_byte,
    input logic                  coll_err
);
    AST_VAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_val)); // R2
    AST_PAY_WITH_VAL: assert property (@(posedge clk) disable iff (!rst_n) ((tx_pay & ~tx_val) == '0)); // R3
    AST_STREAM_LAG: assert property (@(posedge clk) disable iff (!rst_n) (out_vld == $past(tx_val, 2))); // R5
    AST_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_vld == '0) |-> (!out_pay && out_byte == '0)); // R5
    AST_ERR_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) coll_err |-> ($past(tx_val, 2) == '0)); // R7
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (tx_val == '0)); // R8
endmodule

bind tx_gather_master tx_gather_master_chk #(.NUM_SLAVES(NUM_SLAVES), .LANE_W(LANE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tx_val(tx_val), .tx_pay(tx_pay),
    .out_vld(out_vld), .out_pay(out_pay), .out_byte(out_byte), .coll_err(coll_err)
);

// File: tb/tx_gather_master_tb_top.sv
`timescale 1ns/100ps
module tx_gather_master_tb_top;
    localparam int NS = 3;
    localparam int LW = 8;
    localparam int DP = 16;
    localparam int SW = 2;
    localparam int PW = 4;

    typedef struct {
        int         due;
        logic [7:0] b;
        logic       p;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [PW-1:0] sched_last = '0;
    logic cfg_we = 1'b0;
    logic [PW-1:0] cfg_addr = '0;
    logic [SW-1:0] cfg_slave = '0;
    logic cfg_pay = 1'b0;
    logic [NS-1:0] tx_val, tx_pay, out_vld;
    logic [NS*LW-1:0] slv_dat;
    logic out_pay, coll_err;
    logic [LW-1:0] out_byte;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_en = 0;
    bit finished = 0;

    item_t sq [NS][$];
    logic [SW-1:0] m_sl [DP];
    logic          m_py [DP];
    logic [7:0]    ecnt [NS];
    int mp = 0;
    int err_due = -100;
    bit pend = 0;
    int pend_a;
    logic [SW-1:0] pend_s;
    logic pend_p;
    bit arm_glitch = 0;
    logic glitch = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    tx_gather_master dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .sched_last(sched_last),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_slave(cfg_slave), .cfg_pay(cfg_pay),
        .tx_val(tx_val), .tx_pay(tx_pay), .slv_dat(slv_dat),
        .out_vld(out_vld), .out_pay(out_pay), .out_byte(out_byte), .coll_err(coll_err)
    );

    // Slave models: answer one cycle after their valid, zero otherwise
    for (genvar g = 0; g < NS; g++) begin : g_slv
        logic [7:0] cnt;
        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= 8'(8'h11 + 8'h30 * g);
                slv_dat[g*LW +: LW] <= '0;
            end else if (tx_val[g]) begin
                slv_dat[g*LW +: LW] <= cnt;
                cnt <= cnt + 8'd1;
            end else if (g == 0 && glitch) begin
                slv_dat[g*LW +: LW] <= 8'hA5;
            end else begin
                slv_dat[g*LW +: LW] <= '0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Monitor: pops expected items as stream bytes come out
    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i < NS; i++) begin
                if (out_vld[i]) begin
                    if (sq[i].size() == 0) begin
                        chk(1'b0, "R6 unexpected byte", int'(out_byte), 0);
                    end else begin
                        item_t it;
                        it = sq[i].pop_front();
                        chk(it.due == cyc, "R5 arrival cycle", cyc, it.due);
                        chk(out_byte == it.b, "R5 byte value", int'(out_byte), int'(it.b));
                        chk(out_pay == it.p, "R5 payload flag", int'(out_pay), int'(it.p));
                    end
                end
            end
            chk(coll_err == (cyc == err_due), "R7 collision flag", int'(coll_err), int'(cyc == err_due));
        end
    end

    // Driver step: one clock, compare strobes against the schedule model, push expectations
    task automatic step();
        logic rs;
        logic [SW-1:0] s;
        logic p;
        logic [NS-1:0] ev;
        @(posedge clk);
        rs = run;
        @(negedge clk);
        glitch = 1'b0;
        if (!rs) begin
            chk(tx_val == '0, "R8 no valid while stopped", int'(tx_val), 0);
            chk(tx_pay == '0, "R8 no payload while stopped", int'(tx_pay), 0);
            mp = 0;
        end else begin
            s = m_sl[mp];
            p = m_py[mp];
            ev = (int'(s) < NS) ? NS'(1 << s) : '0;
            if (int'(s) < NS) begin
                item_t it;
                chk(tx_val == ev, "R2 valid strobe", int'(tx_val), int'(ev));
                it.due = cyc + 2;
                it.b = ecnt[s];
                it.p = p;
                sq[s].push_back(it);
                ecnt[s] = ecnt[s] + 8'd1;
            end else begin
                chk(tx_val == '0, "R4 idle slot", int'(tx_val), 0);
                if (arm_glitch) begin
                    glitch = 1'b1;
                    err_due = cyc + 2;
                    arm_glitch = 0;
                end
            end
            chk(tx_pay == (p ? ev : '0), "R3 payload strobe", int'(tx_pay), int'(p ? ev : '0));
            mp = (mp >= int'(sched_last)) ? 0 : mp + 1;
        end
        if (pend) begin
            m_sl[pend_a] = pend_s;
            m_py[pend_a] = pend_p;
            pend = 0;
        end
        cfg_we = 1'b0;
    endtask

    task automatic wr(input int a, input int s, input bit p);
        cfg_we = 1'b1;
        cfg_addr = PW'(a);
        cfg_slave = SW'(s);
        cfg_pay = p;
        pend = 1;
        pend_a = a;
        pend_s = SW'(s);
        pend_p = p;
        step();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DP; i++) begin
            m_sl[i] = 2'b11;
            m_py[i] = 1'b0;
        end
        for (int i = 0; i < NS; i++) ecnt[i] = 8'(8'h11 + 8'h30 * i);
        repeat (3) @(negedge clk);
        chk(tx_val == '0 && tx_pay == '0, "R1 strobes in reset", int'({tx_val, tx_pay}), 0);
        chk(out_vld == '0 && coll_err == 1'b0, "R1 outputs in reset", int'({out_vld, coll_err}), 0);
        rst_n = 1'b1;
        mon_en = 1;
        // R1: empty table after reset issues only idle slots from entry 0
        sched_last = 4'd3;
        run = 1'b1;
        steps(5);
        run = 1'b0;
        steps(3);

        // Schedule A: mixed slaves, payload and overhead, one idle slot
        wr(0, 0, 1); wr(1, 1, 0); wr(2, 2, 1); wr(3, 3, 0); wr(4, 0, 1); wr(5, 0, 0);
        sched_last = 4'd5;
        steps(4);                       // R8 stopped: still quiet
        run = 1'b1;
        steps(30);                      // R2 R6 wrap at 5
        run = 1'b0;
        steps(4);

        // Schedule B: sparse 16-entry table, low duty cycle, collision injection
        for (int i = 0; i < DP; i++) wr(i, 3, 0);
        wr(0, 1, 1);
        wr(7, 2, 0);
        sched_last = 4'd15;
        run = 1'b1;
        steps(20);
        arm_glitch = 1;                 // R7: stray byte after an idle slot
        steps(30);
        run = 1'b0;
        steps(4);

        // Schedule C: single-entry table, back-to-back to one slave, then rewritten while running
        wr(0, 2, 1);
        sched_last = 4'd0;
        run = 1'b1;
        steps(8);                       // R6 back to back
        wr(0, 0, 0);                    // R9 write while running
        steps(8);
        wr(0, 1, 1);
        steps(6);
        run = 1'b0;
        steps(5);

        for (int i = 0; i < NS; i++) begin
            chk(sq[i].size() == 0, "R6 all bytes delivered", sq[i].size(), 0);
        end
        finish_run();
    end
endmodule